// File: doc/BRIEF.md
# Echo Threshold Crossing Detector

This block searches a stored ultrasonic echo record for the nearest reflecting object. After a start strobe it reads the record one sample per cycle through a synchronous read port with one cycle of latency, such as a block RAM. Each sample is compared against a stepped threshold profile. The index of the first sample that lies strictly above the profile is reported as the nearest object.

The profile is built from a bank of configuration bytes. Several of these bytes hold two nibbles: the high nibble is used in long-range mode and the low nibble in short-range mode. The profile has three parts:
- a skip region at the start of the record, where no detection is made;
- seven staircase levels, each held for a common step interval;
- a tail level that starts at a programmable position and lasts to the end of the record.

The mode and every configuration byte are captured when a scan starts. The scan stops at the first crossing or after the last sample.

Top module: `echo_xing_detect`

## Requirements
- R1: After reset, `done` is 0, `found` is 0 and `first_idx` is all ones.
- R2: A `start` pulse while no scan is running begins a scan at sample 0. A `start` pulse during a running scan is ignored.
- R3: A crossing is a sample strictly greater than the active threshold; a sample equal to it is not a crossing. At the first crossing k, `done` is high for exactly one cycle, k+2 clock edges after the edge that sampled `start`. In the same cycle `found` is 1 and `first_idx` is k.
- R4: Staircase levels 0..6 are taken from `lvl_pack` bits [8j+7:8j] for level j. They are applied in order, and each is held for one step interval. After level 6 has been reached it is held.
- R5: The step interval is 8 times `step_pack[7:4]` in long mode and 2 times `step_pack[3:0]` in short mode. A nibble value of 0 is treated as 1.
- R6: From sample index 40 times `tail_pos_pack[7:4]` (long mode) or 8 times `tail_pos_pack[3:0]` (short mode) to the end of the record, the tail level replaces the staircase. This holds even if not all staircase steps have elapsed.
- R7: The tail level is 5 times `tail_lvl` in long mode, saturating at 255, and `tail_lvl` unscaled in short mode.
- R8: Samples with an index below `skip_pack[7:4]` (long mode) or `skip_pack[3:0]` (short mode) are never reported.
- R9: If no sample of the 768-sample record crosses, `done` pulses 769 edges after the start edge. In that cycle `found` is 0 and `first_idx` is all ones.
- R10: `found` and `first_idx` hold their values until the next accepted start. An accepted start clears them to 0 and all ones on the edge that accepts it.
- R11: The mode and all configuration inputs are captured at the accepted start. Changes to them during a scan do not affect the result.
- R12: `long_mode` = 1 selects long range and 0 selects short range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Scan start strobe |
| long_mode | input | 1 | 1 = long range, 0 = short range |
| lvl_pack | input | 56 | Staircase levels 0..6, level j in bits [8j+7:8j] |
| tail_lvl | input | 8 | Tail level before scaling |
| tail_pos_pack | input | 8 | Tail start position nibbles (high = long, low = short) |
| step_pack | input | 8 | Step interval nibbles (high = long, low = short) |
| skip_pack | input | 8 | Skip count nibbles (high = long, low = short) |
| rd_addr | output | 10 | Sample read address |
| rd_data | input | 8 | Sample read data, valid one cycle after the address |
| done | output | 1 | One-cycle end-of-scan pulse |
| found | output | 1 | A crossing was found in the last scan |
| first_idx | output | 10 | Index of the first crossing, all ones if none |

## Verification
The assertions assume that `rd_data` returns the sample at the previous cycle's `rd_addr`. They also assume that `start` is a single-cycle strobe synchronous to `clk`. The bench models the record as a registered array indexed by `rd_addr`, and drives `start` and the configuration only at falling edges. Configuration changes during a scan are made on purpose, so that R11 is exercised while the read protocol stays intact.

// File: rtl/echo_pkg.sv
package echo_pkg;
  localparam int NLEV           = 7;
  localparam int TS_W           = 16;
  localparam int LONG_STEP_MUL  = 8;
  localparam int SHORT_STEP_MUL = 2;
  localparam int LONG_TAIL_MUL  = 40;
  localparam int SHORT_TAIL_MUL = 8;
  localparam int LONG_TAIL_GAIN = 5;

  typedef struct packed {
    logic [7:0]      step_len;
    logic [TS_W-1:0] tail_start;
    logic [3:0]      skip;
  } prof_t;

  function automatic logic [3:0] pick_nib(input logic [7:0] v, input logic long_m);
    return long_m ? v[7:4] : v[3:0];
  endfunction
endpackage

// File: rtl/echo_prof_latch.sv
module echo_prof_latch
  import echo_pkg::*;
#(
  parameter int SW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             long_mode,
  input  logic [NLEV*SW-1:0] lvl_pack,
  input  logic [SW-1:0]    tail_lvl,
  input  logic [7:0]       tail_pos_pack,
  input  logic [7:0]       step_pack,
  input  logic [7:0]       skip_pack,
  output prof_t            prof,
  output logic [SW-1:0]    tail_val,
  output logic [NLEV*SW-1:0] lvl_q
);
  localparam int GW = SW + 3;
  localparam logic [GW-1:0] SAT_MAX = GW'((1 << SW) - 1);

  logic [3:0]    step_n, pos_n;
  logic [7:0]    step_len_d;
  logic [TS_W-1:0] tail_start_d;
  logic [GW-1:0] gain;
  logic [SW-1:0] tail_d;

  always_comb begin
    step_n = pick_nib(step_pack, long_mode);
    if (step_n == 4'd0) step_n = 4'd1;
    pos_n  = pick_nib(tail_pos_pack, long_mode);
    step_len_d   = long_mode ? 8'(step_n * LONG_STEP_MUL) : 8'(step_n * SHORT_STEP_MUL);
    tail_start_d = long_mode ? TS_W'(pos_n * LONG_TAIL_MUL) : TS_W'(pos_n * SHORT_TAIL_MUL);
    gain   = long_mode ? GW'(tail_lvl) * GW'(LONG_TAIL_GAIN) : GW'(tail_lvl);
    tail_d = (gain > SAT_MAX) ? {SW{1'b1}} : gain[SW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prof.step_len   <= 8'd1;
      prof.tail_start <= '0;
      prof.skip       <= '0;
      tail_val        <= '0;
    end else if (load) begin
      prof.step_len   <= step_len_d;
      prof.tail_start <= tail_start_d;
      prof.skip       <= pick_nib(skip_pack, long_mode);
      tail_val        <= tail_d;
    end
  end

  for (genvar j = 0; j < NLEV; j++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (rst)       lvl_q[j*SW +: SW] <= '0;
      else if (load) lvl_q[j*SW +: SW] <= lvl_pack[j*SW +: SW];
    end
  end

  p_short_unscaled_r7: assert property (@(posedge clk) disable iff (rst)
    (load && !long_mode) |=> (tail_val == $past(tail_lvl)));
  p_step_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    prof.step_len != 8'd0);
endmodule

// File: rtl/echo_thr_seq.sv
module echo_thr_seq
  import echo_pkg::*;
#(
  parameter int SW = 8,
  parameter int IW = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               adv,
  input  logic               kill,
  input  logic [IW-1:0]      idx_in,
  input  logic [7:0]         step_len,
  input  logic [TS_W-1:0]    tail_start,
  input  logic [SW-1:0]      tail_val,
  input  logic [NLEV*SW-1:0] lvl_q,
  output logic [SW-1:0]      thr_q,
  output logic [IW-1:0]      idx_q,
  output logic               vld_q
);
  localparam int LW = $clog2(NLEV);
  localparam logic [LW-1:0] LAST_LVL = LW'(NLEV - 1);

  logic [7:0]    sc;
  logic [LW-1:0] lvl;
  logic [SW-1:0] stair;
  logic          in_tail;

  always_comb begin
    stair   = lvl_q[lvl*SW +: SW];
    in_tail = {{(TS_W-IW){1'b0}}, idx_in} >= tail_start;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sc <= '0; lvl <= '0; vld_q <= 1'b0; thr_q <= '0; idx_q <= '0;
    end else if (load) begin
      sc <= '0; lvl <= '0; vld_q <= 1'b0;
    end else begin
      vld_q <= adv && !kill;
      if (adv) begin
        thr_q <= in_tail ? tail_val : stair;
        idx_q <= idx_in;
        if (sc == step_len - 8'd1) begin
          sc <= '0;
          if (lvl != LAST_LVL) lvl <= lvl + 1'b1;
        end else begin
          sc <= sc + 8'd1;
        end
      end
    end
  end

  p_level_bound_r4: assert property (@(posedge clk) disable iff (rst)
    lvl <= LAST_LVL);
  p_level_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (lvl == LAST_LVL && !load) |=> (lvl == LAST_LVL || $past(load)));
endmodule

// File: rtl/echo_hit_capture.sv
module echo_hit_capture #(
  parameter int SW    = 8,
  parameter int IW    = 10,
  parameter int NSAMP = 768
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          vld,
  input  logic [IW-1:0] idx,
  input  logic [SW-1:0] sample,
  input  logic [SW-1:0] thr,
  input  logic [3:0]    skip,
  output logic          fin,
  output logic          done,
  output logic          found,
  output logic [IW-1:0] first_idx
);
  localparam logic [IW-1:0] LAST_IDX = IW'(NSAMP - 1);

  logic hit, last;

  always_comb begin
    hit  = vld && (idx >= IW'(skip)) && (sample > thr);
    last = vld && (idx == LAST_IDX);
    fin  = hit || last;
  end

  always_ff @(posedge clk) begin
    if (rst || load) begin
      done      <= 1'b0;
      found     <= 1'b0;
      first_idx <= '1;
    end else begin
      done <= fin;
      if (hit) begin
        found     <= 1'b1;
        first_idx <= idx;
      end
    end
  end

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_found_with_done_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(found) |-> done);
  p_miss_ones_r9: assert property (@(posedge clk) disable iff (rst)
    (done && !found) |-> (&first_idx));
  p_skip_region_r8: assert property (@(posedge clk) disable iff (rst)
    found |-> (first_idx >= IW'(skip)));
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (found && !load) |=> (found && $stable(first_idx)));
endmodule

// File: rtl/echo_xing_detect.sv
module echo_xing_detect
  import echo_pkg::*;
#(
  parameter int NSAMP = 768,
  parameter int SW    = 8,
  localparam int IW   = $clog2(NSAMP)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               long_mode,
  input  logic [NLEV*SW-1:0] lvl_pack,
  input  logic [SW-1:0]      tail_lvl,
  input  logic [7:0]         tail_pos_pack,
  input  logic [7:0]         step_pack,
  input  logic [7:0]         skip_pack,
  output logic [IW-1:0]      rd_addr,
  input  logic [SW-1:0]      rd_data,
  output logic               done,
  output logic               found,
  output logic [IW-1:0]      first_idx
);
  localparam logic [IW-1:0] LAST_IDX = IW'(NSAMP - 1);

  logic              run, iss_vld, load, fin;
  prof_t             prof;
  logic [SW-1:0]     tail_val, thr_q;
  logic [NLEV*SW-1:0] lvl_q;
  logic [IW-1:0]     cmp_idx;
  logic              cmp_vld;

  assign load = start && !run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0; iss_vld <= 1'b0; rd_addr <= '0;
    end else if (load) begin
      run <= 1'b1; iss_vld <= 1'b1; rd_addr <= '0;
    end else if (fin) begin
      run <= 1'b0; iss_vld <= 1'b0;
    end else if (iss_vld) begin
      if (rd_addr == LAST_IDX) iss_vld <= 1'b0;
      else                     rd_addr <= rd_addr + 1'b1;
    end
  end

  echo_prof_latch #(.SW(SW)) u_prof (
    .clk(clk), .rst(rst), .load(load), .long_mode(long_mode),
    .lvl_pack(lvl_pack), .tail_lvl(tail_lvl), .tail_pos_pack(tail_pos_pack),
    .step_pack(step_pack), .skip_pack(skip_pack),
    .prof(prof), .tail_val(tail_val), .lvl_q(lvl_q)
  );

  echo_thr_seq #(.SW(SW), .IW(IW)) u_thr (
    .clk(clk), .rst(rst), .load(load), .adv(iss_vld), .kill(fin),
    .idx_in(rd_addr), .step_len(prof.step_len), .tail_start(prof.tail_start),
    .tail_val(tail_val), .lvl_q(lvl_q),
    .thr_q(thr_q), .idx_q(cmp_idx), .vld_q(cmp_vld)
  );

  echo_hit_capture #(.SW(SW), .IW(IW), .NSAMP(NSAMP)) u_cap (
    .clk(clk), .rst(rst), .load(load), .vld(cmp_vld), .idx(cmp_idx),
    .sample(rd_data), .thr(thr_q), .skip(prof.skip),
    .fin(fin), .done(done), .found(found), .first_idx(first_idx)
  );

  p_addr_range_r2: assert property (@(posedge clk) disable iff (rst)
    rd_addr <= LAST_IDX);
  p_done_ends_run_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> !run);
  p_restart_clears_r10: assert property (@(posedge clk) disable iff (rst)
    load |=> (!found && (&first_idx)));
endmodule

// File: tb/echo_xing_detect_test.sv
module echo_xing_detect_test;
  localparam int NS = 768;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, long_mode = 1'b0;
  logic [55:0] lvl_pack = '0;
  logic [7:0] tail_lvl = '0, tail_pos_pack = '0, step_pack = '0, skip_pack = '0;
  logic [9:0] rd_addr, first_idx;
  logic [7:0] rd_data;
  logic done, found;

  logic [7:0] mem [0:NS-1];
  int lv [7];
  int c_tl, c_tp, c_st, c_sk;
  logic c_lm;
  int checks = 0, errors = 0, cycles = 0;

  always #2 clk = ~clk;
  always @(posedge clk) rd_data <= mem[rd_addr];

  echo_xing_detect uut (
    .clk(clk), .rst(rst), .start(start), .long_mode(long_mode),
    .lvl_pack(lvl_pack), .tail_lvl(tail_lvl), .tail_pos_pack(tail_pos_pack),
    .step_pack(step_pack), .skip_pack(skip_pack), .rd_addr(rd_addr),
    .rd_data(rd_data), .done(done), .found(found), .first_idx(first_idx)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int nib(input int v, input logic lm);
    return lm ? (v >> 4) & 15 : v & 15;
  endfunction

  function automatic int m_thr(input int i);
    int sn, iv, ts, tv, k;
    sn = nib(c_st, c_lm); if (sn == 0) sn = 1;
    iv = c_lm ? sn * 8 : sn * 2;
    ts = c_lm ? nib(c_tp, 1) * 40 : nib(c_tp, 0) * 8;
    tv = c_lm ? c_tl * 5 : c_tl;
    if (tv > 255) tv = 255;
    if (i >= ts) return tv;
    k = i / iv; if (k > 6) k = 6;
    return lv[k];
  endfunction

  function automatic int m_first();
    for (int i = nib(c_sk, c_lm); i < NS; i++)
      if (int'(mem[i]) > m_thr(i)) return i;
    return -1;
  endfunction

  task automatic clear_mem(input logic [7:0] v);
    for (int i = 0; i < NS; i++) mem[i] = v;
  endtask

  task automatic set_cfg(input logic lm, input int l0, input int l1, input int l2,
                         input int l3, input int l4, input int l5, input int l6,
                         input int tl, input int tp, input int st, input int sk);
    lv[0] = l0; lv[1] = l1; lv[2] = l2; lv[3] = l3; lv[4] = l4; lv[5] = l5; lv[6] = l6;
    c_lm = lm; c_tl = tl; c_tp = tp; c_st = st; c_sk = sk;
  endtask

  task automatic drive_cfg();
    for (int j = 0; j < 7; j++) lvl_pack[j*8 +: 8] = 8'(lv[j]);
    long_mode = c_lm; tail_lvl = 8'(c_tl); tail_pos_pack = 8'(c_tp);
    step_pack = 8'(c_st); skip_pack = 8'(c_sk);
  endtask

  task automatic wait_done(inout int lat);
    while (!done && lat < 2000) begin
      @(posedge clk); lat++; @(negedge clk);
    end
  endtask

  task automatic scan_check(input string tag, input int exp_hard);
    int lat, e;
    e = m_first();
    chk(e == exp_hard, {tag, " model"}, e, exp_hard);
    @(negedge clk); drive_cfg(); start = 1'b1;
    @(posedge clk); @(negedge clk); start = 1'b0; lat = 0;
    wait_done(lat);
    chk(done == 1'b1, {tag, " done R3"}, int'(done), 1);
    chk(found == (e >= 0), {tag, " found"}, int'(found), int'(e >= 0));
    chk(first_idx == ((e >= 0) ? 10'(e) : 10'h3FF), {tag, " idx"}, int'(first_idx), e);
    chk(lat == ((e >= 0) ? e + 2 : NS + 1), {tag, " latency"}, lat, (e >= 0) ? e + 2 : NS + 1);
    @(negedge clk);
    chk(done == 1'b0, {tag, " done pulse R3"}, int'(done), 0);
  endtask

  task automatic t_reset();
    chk(done == 0 && found == 0 && first_idx == 10'h3FF, "R1 reset", int'(first_idx), 1023);
  endtask

  task automatic t_strict_stairs();
    clear_mem(8'd0);
    set_cfg(0, 100, 90, 80, 70, 60, 50, 40, 0, 8'h0F, 8'h03, 0);
    mem[7] = 8'd90; mem[13] = 8'd81;
    scan_check("R3 R4 R5 R12 short stairs", 13);
  endtask

  task automatic t_level6_hold();
    clear_mem(8'd0);
    set_cfg(1, 250, 240, 230, 220, 210, 200, 190, 0, 8'hF0, 8'h10, 0);
    mem[40] = 8'd195; mem[100] = 8'd191;
    scan_check("R4 long level6 hold", 100);
  endtask

  task automatic t_nibble_zero();
    clear_mem(8'd0);
    set_cfg(0, 100, 90, 80, 70, 60, 50, 40, 0, 8'hFF, 8'h00, 0);
    mem[3] = 8'd75; mem[4] = 8'd81;
    scan_check("R5 zero step nibble", 4);
  endtask

  task automatic t_tail();
    clear_mem(8'd0);
    set_cfg(1, 255, 255, 255, 255, 255, 255, 255, 40, 8'h20, 8'h11, 0);
    mem[85] = 8'd200; mem[90] = 8'd201;
    scan_check("R6 R7 long tail scaled", 90);
    clear_mem(8'd255);
    set_cfg(1, 255, 255, 255, 255, 255, 255, 255, 60, 8'h20, 8'h11, 0);
    scan_check("R7 tail saturation", -1);
    clear_mem(8'd0);
    set_cfg(0, 255, 255, 255, 255, 255, 255, 255, 40, 8'h01, 8'h11, 0);
    mem[9] = 8'd40; mem[10] = 8'd41;
    scan_check("R6 R7 short tail unscaled", 10);
  endtask

  task automatic t_skip();
    clear_mem(8'd0);
    set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 10, 8'h00, 8'h11, 8'h95);
    mem[3] = 8'd255; mem[6] = 8'd255; mem[9] = 8'd255;
    scan_check("R8 short skip", 6);
    set_cfg(1, 0, 0, 0, 0, 0, 0, 0, 10, 8'h00, 8'h11, 8'h95);
    scan_check("R8 long skip", 9);
  endtask

  task automatic t_miss_hold();
    clear_mem(8'd0);
    set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h33, 8'h22, 0);
    scan_check("R9 no crossing", -1);
    clear_mem(8'd0);
    set_cfg(0, 50, 50, 50, 50, 50, 50, 50, 50, 8'hFF, 8'h22, 0);
    mem[20] = 8'd60;
    scan_check("R10 setup", 20);
    repeat (10) @(negedge clk);
    chk(found == 1 && first_idx == 10'd20, "R10 hold", int'(first_idx), 20);
    drive_cfg(); start = 1'b1;
    @(posedge clk); @(negedge clk); start = 1'b0;
    chk(found == 0 && first_idx == 10'h3FF, "R10 clear on start", int'(first_idx), 1023);
    repeat (30) @(negedge clk);
  endtask

  task automatic t_midscan();
    int lat;
    clear_mem(8'd0);
    set_cfg(0, 200, 200, 200, 200, 200, 200, 200, 100, 8'h0F, 8'h0F, 0);
    mem[500] = 8'd150;
    chk(m_first() == 500, "R2 R11 model", m_first(), 500);
    @(negedge clk); drive_cfg(); start = 1'b1;
    @(posedge clk); @(negedge clk); start = 1'b0; lat = 0;
    repeat (50) begin @(posedge clk); lat++; @(negedge clk); end
    long_mode = 1'b1; step_pack = 8'h00; tail_lvl = 8'd255; start = 1'b1;
    @(posedge clk); lat++; @(negedge clk); start = 1'b0;
    wait_done(lat);
    chk(found == 1 && first_idx == 10'd500, "R2 R11 restart ignored", int'(first_idx), 500);
    chk(lat == 502, "R2 latency unchanged", lat, 502);
  endtask

  initial begin
    clear_mem(8'd0);
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_strict_stairs();
    t_level6_hold();
    t_nibble_zero();
    t_tail();
    t_skip();
    t_miss_hold();
    t_midscan();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule